// File: doc/BRIEF.md
# Dual-Mapped Peripheral Register Access Unit

This unit decodes register accesses for a small 8-bit processor core. One register set is reachable through two ports. The short-address I/O port carries byte reads, byte writes and single-bit set, clear and test operations. The load/store port sees the same registers shifted up by 0x20 in data space, and it also reaches an extended region above the I/O window.

The unit holds three general-purpose 8-bit scratch registers at I/O addresses 0x00, 0x01 and 0x02. It also holds one example status register at I/O address 0x05 with four write-one-to-clear event flags in bits 3:0, which the peripheral logic raises through an event input. Bit operations work only in the lower half of the I/O window. A single-bit operation acts on the named bit alone, so it never clears other pending flags. Reads and bit-test results appear one cycle after the request. Accesses outside a port's valid range return a one-cycle error strobe and change nothing.

Top module: `periph_reg_access`

## Requirements
- R1: While reset is low, and in the first cycle after it, every output is 0, all scratch registers read 0x00 and the status register reads 0x00.
- R2: I/O operation codes are 0 = read, 1 = byte write, 2 = set bit, 3 = clear bit and 4 = test bit. A read returns the addressed byte on `ioRData` in the cycle after the request. When the cycle before held no successful read on that port, `ioRData` is 0. The same rule holds for `dsRData`.
- R3: The register at I/O address A is read and written on the load/store port at data address A + 0x20.
- R4: Set bit (code 2) and clear bit (code 3) change only the bit selected by `ioBitSel` in a scratch register.
- R5: Test bit (code 4) drives `ioBitResult` to the selected bit's value in the cycle after the request. In every other cycle `ioBitResult` is 0.
- R6: On the I/O port, a bit operation (codes 2 to 4) at an address of 0x20 or above, or any operation code from 5 to 7, raises `ioError` for one cycle and changes no state.
- R7: An I/O port access at an address of 0x40 or above raises `ioError` and changes no state. Load/store accesses to data addresses 0x60 to 0xFF raise no error, read 0 and have no effect.
- R8: Each bit of `evtSet` sets the matching status flag. Writing a one to a flag clears it, and writing a zero leaves it unchanged. If an event and a clear hit the same flag in the same cycle, the flag stays set.
- R9: Set bit on a status flag clears only that flag, and clear bit on a status flag has no effect. In both cases the other pending flags are kept.
- R10: Status bits 7:4 read as 0. Unimplemented I/O addresses (0x03, 0x04 and 0x06 to 0x3F) read 0 and ignore writes.
- R11: When both ports write the same register in one cycle, the load/store write is applied and the I/O write is dropped. Writes from the two ports to different registers both take effect.
- R12: A load/store access below data address 0x20 raises `dsError` for one cycle and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ioValid | input | 1 | I/O port request |
| ioOp | input | 3 | I/O operation code |
| ioAddr | input | 8 | I/O address (valid range 0x00 to 0x3F) |
| ioBitSel | input | 3 | Bit index for bit operations |
| ioWData | input | 8 | I/O byte write data |
| dsValid | input | 1 | Load/store port request |
| dsWrite | input | 1 | Load/store direction: 1 = store, 0 = load |
| dsAddr | input | 8 | Data-space address |
| dsWData | input | 8 | Store data |
| evtSet | input | 4 | Peripheral events that set status flags |
| ioRData | output | 8 | I/O read data, one cycle after the request |
| ioBitResult | output | 1 | Bit-test result, one cycle after the request |
| ioError | output | 1 | I/O range or operation error strobe |
| dsRData | output | 8 | Load data, one cycle after the request |
| dsError | output | 1 | Load/store range error strobe |

## Verification
The hardest case to reach from the ports is a single-bit set on the status register while other flags are still pending, together with the same-cycle collisions between an event, a clear and a write on the other port. The stimulus first raises several flags through `evtSet` and then applies set-bit and clear-bit operations on flag bits. It follows with a phase of mixed traffic from a pseudo-random generator in which the two ports often target the same register while events keep arriving. After every clock the outputs are compared against a behavioural model.

// File: rtl/prau_pkg.sv
package prau_pkg;

  localparam int unsigned DATA_W  = 8;
  localparam int unsigned PORT_AW = 8;
  localparam int unsigned IO_AW   = 6;
  localparam int unsigned BIT_W   = $clog2(DATA_W);

  typedef enum logic [2:0] {
    OP_READ  = 3'd0,
    OP_WRITE = 3'd1,
    OP_SETB  = 3'd2,
    OP_CLRB  = 3'd3,
    OP_TEST  = 3'd4
  } ioOp_e;

  typedef struct packed {
    logic              ioRd;
    logic              ioTst;
    logic              ioWr;
    logic              ioErr;
    logic [IO_AW-1:0]  ioAddr;
    logic [BIT_W-1:0]  ioBit;
    logic [DATA_W-1:0] ioMask;
    logic [DATA_W-1:0] ioData;
    logic              dsRd;
    logic              dsWr;
    logic              dsErr;
    logic [IO_AW-1:0]  dsAddr;
    logic [DATA_W-1:0] dsData;
  } ctrlStrobes_t;

endpackage

// File: rtl/prau_ctrl.sv
module prau_ctrl
  import prau_pkg::*;
#(
  parameter int unsigned IO_SPAN   = 64,
  parameter int unsigned BIT_SPAN  = 32,
  parameter int unsigned DS_OFFSET = 32
) (
  input  logic               ioValid,
  input  logic [2:0]         ioOp,
  input  logic [PORT_AW-1:0] ioAddr,
  input  logic [BIT_W-1:0]   ioBitSel,
  input  logic [DATA_W-1:0]  ioWData,
  input  logic               dsValid,
  input  logic               dsWrite,
  input  logic [PORT_AW-1:0] dsAddr,
  input  logic [DATA_W-1:0]  dsWData,
  output ctrlStrobes_t       strb
);

  localparam int unsigned DS_END = DS_OFFSET + IO_SPAN;

  logic              ioKnownOp;
  logic              ioBitOp;
  logic              ioOutRange;
  logic              ioBitBad;
  logic              dsLow;
  logic              dsInWin;
  logic [PORT_AW-1:0] dsRel;
  logic [DATA_W-1:0] bitMask;

  assign ioKnownOp  = (ioOp <= OP_TEST);
  assign ioBitOp    = (ioOp == OP_SETB) || (ioOp == OP_CLRB) || (ioOp == OP_TEST);
  assign ioOutRange = (int'(ioAddr) >= int'(IO_SPAN));
  assign ioBitBad   = ioBitOp && (int'(ioAddr) >= int'(BIT_SPAN));
  assign dsLow      = (int'(dsAddr) < int'(DS_OFFSET));
  assign dsInWin    = !dsLow && (int'(dsAddr) < int'(DS_END));
  assign dsRel      = dsAddr - PORT_AW'(DS_OFFSET);
  assign bitMask    = DATA_W'(1) << ioBitSel;

  always_comb begin
    strb        = '0;
    strb.ioAddr = ioAddr[IO_AW-1:0];
    strb.ioBit  = ioBitSel;
    strb.dsAddr = dsRel[IO_AW-1:0];
    strb.dsData = dsWData;

    if (ioValid) begin
      if (!ioKnownOp || ioOutRange || ioBitBad) begin
        strb.ioErr = 1'b1;
      end else begin
        case (ioOp_e'(ioOp))
          OP_READ:  strb.ioRd = 1'b1;
          OP_WRITE: begin
            strb.ioWr   = 1'b1;
            strb.ioMask = '1;
            strb.ioData = ioWData;
          end
          OP_SETB: begin
            strb.ioWr   = 1'b1;
            strb.ioMask = bitMask;
            strb.ioData = '1;
          end
          OP_CLRB: begin
            strb.ioWr   = 1'b1;
            strb.ioMask = bitMask;
            strb.ioData = '0;
          end
          OP_TEST:  strb.ioTst = 1'b1;
          default:  strb.ioErr = 1'b1;
        endcase
      end
    end

    if (dsValid) begin
      if (dsLow) begin
        strb.dsErr = 1'b1;
      end else if (dsInWin) begin
        strb.dsWr = dsWrite;
        strb.dsRd = !dsWrite;
      end
    end
  end

endmodule

// File: rtl/prau_datapath.sv
module prau_datapath
  import prau_pkg::*;
#(
  parameter int unsigned NUM_SCRATCH  = 3,
  parameter int unsigned SCRATCH_BASE = 0,
  parameter int unsigned STATUS_ADDR  = 5,
  parameter int unsigned FLAG_W       = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic [FLAG_W-1:0] evtSet,
  output logic [DATA_W-1:0] ioRData,
  output logic              ioBitResult,
  output logic              ioError,
  output logic [DATA_W-1:0] dsRData,
  output logic              dsError
);

  localparam logic [IO_AW-1:0] STAT_A = IO_AW'(STATUS_ADDR);

  logic [DATA_W-1:0] scratchQ [NUM_SCRATCH];
  logic [FLAG_W-1:0] flagsQ;
  logic [DATA_W-1:0] ioRdVal;
  logic [DATA_W-1:0] dsRdVal;
  logic [DATA_W-1:0] flagClr;

  for (genvar i = 0; i < NUM_SCRATCH; i++) begin : g_scratch
    localparam logic [IO_AW-1:0] ADDR = IO_AW'(SCRATCH_BASE + i);
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        q <= '0;
      end else if (strb.dsWr && strb.dsAddr == ADDR) begin
        q <= strb.dsData;
      end else if (strb.ioWr && strb.ioAddr == ADDR) begin
        q <= (q & ~strb.ioMask) | (strb.ioData & strb.ioMask);
      end
    end
    assign scratchQ[i] = q;
  end

  // write-one-to-clear: the winning port's ones clear flags
  always_comb begin
    flagClr = '0;
    if (strb.dsWr && strb.dsAddr == STAT_A) begin
      flagClr = strb.dsData;
    end else if (strb.ioWr && strb.ioAddr == STAT_A) begin
      flagClr = strb.ioMask & strb.ioData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagsQ <= '0;
    else       flagsQ <= (flagsQ & ~flagClr[FLAG_W-1:0]) | evtSet;
  end

  function automatic logic [DATA_W-1:0] readAt(input logic [IO_AW-1:0] a);
    logic [DATA_W-1:0] v;
    v = '0;
    for (int i = 0; i < int'(NUM_SCRATCH); i++) begin
      if (a == IO_AW'(SCRATCH_BASE + i)) v = scratchQ[i];
    end
    if (a == STAT_A) v = DATA_W'(flagsQ);
    return v;
  endfunction

  assign ioRdVal = readAt(strb.ioAddr);
  assign dsRdVal = readAt(strb.dsAddr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ioRData     <= '0;
      ioBitResult <= 1'b0;
      ioError     <= 1'b0;
      dsRData     <= '0;
      dsError     <= 1'b0;
    end else begin
      ioRData     <= strb.ioRd  ? ioRdVal : '0;
      ioBitResult <= strb.ioTst ? ioRdVal[strb.ioBit] : 1'b0;
      ioError     <= strb.ioErr;
      dsRData     <= strb.dsRd  ? dsRdVal : '0;
      dsError     <= strb.dsErr;
    end
  end

endmodule

// File: rtl/periph_reg_access.sv
module periph_reg_access
  import prau_pkg::*;
#(
  parameter int unsigned NUM_SCRATCH  = 3,
  parameter int unsigned SCRATCH_BASE = 0,
  parameter int unsigned STATUS_ADDR  = 5,
  parameter int unsigned FLAG_W       = 4,
  parameter int unsigned IO_SPAN      = 64,
  parameter int unsigned BIT_SPAN     = 32,
  parameter int unsigned DS_OFFSET    = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ioValid,
  input  logic [2:0]         ioOp,
  input  logic [PORT_AW-1:0] ioAddr,
  input  logic [BIT_W-1:0]   ioBitSel,
  input  logic [DATA_W-1:0]  ioWData,
  input  logic               dsValid,
  input  logic               dsWrite,
  input  logic [PORT_AW-1:0] dsAddr,
  input  logic [DATA_W-1:0]  dsWData,
  input  logic [FLAG_W-1:0]  evtSet,
  output logic [DATA_W-1:0]  ioRData,
  output logic               ioBitResult,
  output logic               ioError,
  output logic [DATA_W-1:0]  dsRData,
  output logic               dsError
);

  ctrlStrobes_t strb;

  prau_ctrl #(
    .IO_SPAN   (IO_SPAN),
    .BIT_SPAN  (BIT_SPAN),
    .DS_OFFSET (DS_OFFSET)
  ) ctrl_i (
    .ioValid  (ioValid),
    .ioOp     (ioOp),
    .ioAddr   (ioAddr),
    .ioBitSel (ioBitSel),
    .ioWData  (ioWData),
    .dsValid  (dsValid),
    .dsWrite  (dsWrite),
    .dsAddr   (dsAddr),
    .dsWData  (dsWData),
    .strb     (strb)
  );

  prau_datapath #(
    .NUM_SCRATCH  (NUM_SCRATCH),
    .SCRATCH_BASE (SCRATCH_BASE),
    .STATUS_ADDR  (STATUS_ADDR),
    .FLAG_W       (FLAG_W)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .evtSet      (evtSet),
    .ioRData     (ioRData),
    .ioBitResult (ioBitResult),
    .ioError     (ioError),
    .dsRData     (dsRData),
    .dsError     (dsError)
  );

endmodule

// File: rtl/prau_checker.sv
module prau_checker
  import prau_pkg::*;
#(
  parameter int unsigned FLAG_W    = 4,
  parameter int unsigned IO_SPAN   = 64,
  parameter int unsigned BIT_SPAN  = 32,
  parameter int unsigned DS_OFFSET = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               ioValid,
  input logic [2:0]         ioOp,
  input logic [PORT_AW-1:0] ioAddr,
  input logic               dsValid,
  input logic               dsWrite,
  input logic [PORT_AW-1:0] dsAddr,
  input logic [DATA_W-1:0]  ioRData,
  input logic               ioBitResult,
  input logic               ioError,
  input logic [DATA_W-1:0]  dsRData,
  input logic               dsError
);

  localparam int unsigned DS_END = DS_OFFSET + IO_SPAN;

  // R6: bit operation above the bit window is rejected
  a_r6_bitop_high_err: assert property (@(posedge clk) disable iff (!rstN)
    (ioValid && ioOp >= 3'd2 && ioOp <= 3'd4 && int'(ioAddr) >= int'(BIT_SPAN))
      |=> ioError);

  // R7: short-address port beyond its window is rejected
  a_r7_io_range_err: assert property (@(posedge clk) disable iff (!rstN)
    (ioValid && int'(ioAddr) >= int'(IO_SPAN)) |=> (ioError && ioRData == '0));

  // R7: extended region loads read zero without error
  a_r7_ext_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    (dsValid && !dsWrite && int'(dsAddr) >= int'(DS_END))
      |=> (dsRData == '0 && !dsError));

  // R12: load/store below the window is rejected
  a_r12_ds_low_err: assert property (@(posedge clk) disable iff (!rstN)
    (dsValid && int'(dsAddr) < int'(DS_OFFSET)) |=> dsError);

  // R5: bit result only after a test request
  a_r5_bit_only_on_test: assert property (@(posedge clk) disable iff (!rstN)
    !(ioValid && ioOp == 3'd4) |=> !ioBitResult);

  // R2: no read data without a read request
  a_r2_rdata_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !ioValid |=> (ioRData == '0 && !ioError));

endmodule

bind periph_reg_access prau_checker #(
  .FLAG_W    (FLAG_W),
  .IO_SPAN   (IO_SPAN),
  .BIT_SPAN  (BIT_SPAN),
  .DS_OFFSET (DS_OFFSET)
) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .ioValid     (ioValid),
  .ioOp        (ioOp),
  .ioAddr      (ioAddr),
  .dsValid     (dsValid),
  .dsWrite     (dsWrite),
  .dsAddr      (dsAddr),
  .ioRData     (ioRData),
  .ioBitResult (ioBitResult),
  .ioError     (ioError),
  .dsRData     (dsRData),
  .dsError     (dsError)
);

// File: tb/periph_reg_access_tb_top.sv
module periph_reg_access_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ioValid = 1'b0;
  logic [2:0] ioOp = '0;
  logic [7:0] ioAddr = '0;
  logic [2:0] ioBitSel = '0;
  logic [7:0] ioWData = '0;
  logic       dsValid = 1'b0;
  logic       dsWrite = 1'b0;
  logic [7:0] dsAddr = '0;
  logic [7:0] dsWData = '0;
  logic [3:0] evtSet = '0;
  logic [7:0] ioRData;
  logic       ioBitResult;
  logic       ioError;
  logic [7:0] dsRData;
  logic       dsError;

  int checks = 0;
  int errors = 0;

  // behavioural model state
  int scr [3];
  int flg = 0;
  int eIoR = 0, eBit = 0, eIoE = 0, eDsR = 0, eDsE = 0;
  int lfsr = 32'h1234_5678;

  always #(CLK_PERIOD / 2) clk = ~clk;

  periph_reg_access dut_i (
    .clk (clk), .rstN (rstN),
    .ioValid (ioValid), .ioOp (ioOp), .ioAddr (ioAddr), .ioBitSel (ioBitSel),
    .ioWData (ioWData), .dsValid (dsValid), .dsWrite (dsWrite), .dsAddr (dsAddr),
    .dsWData (dsWData), .evtSet (evtSet), .ioRData (ioRData),
    .ioBitResult (ioBitResult), .ioError (ioError), .dsRData (dsRData),
    .dsError (dsError)
  );

  function automatic int rdReg(int a);
    if (a < 3) return scr[a];
    if (a == 5) return flg;
    return 0;
  endfunction

  task automatic cmp(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  // one model step for the inputs currently applied
  task automatic modelStep();
    int ioW = 0, ioA = 0, ioM = 0, ioD = 0;
    int dsW = 0, dsA = 0, dsD = 0;
    int clr = 0;
    bit bitOp;
    eIoR = 0; eBit = 0; eIoE = 0; eDsR = 0; eDsE = 0;
    if (ioValid) begin
      bitOp = (ioOp >= 2 && ioOp <= 4);
      if (ioAddr >= 8'h40 || ioOp > 4 || (bitOp && ioAddr >= 8'h20)) eIoE = 1;
      else begin
        case (ioOp)
          3'd0: eIoR = rdReg(ioAddr);
          3'd1: begin ioW = 1; ioA = ioAddr; ioM = 255; ioD = ioWData; end
          3'd2: begin ioW = 1; ioA = ioAddr; ioM = 1 << ioBitSel; ioD = 255; end
          3'd3: begin ioW = 1; ioA = ioAddr; ioM = 1 << ioBitSel; ioD = 0; end
          default: eBit = (rdReg(ioAddr) >> ioBitSel) & 1;
        endcase
      end
    end
    if (dsValid) begin
      if (dsAddr < 8'h20) eDsE = 1;
      else if (dsAddr < 8'h60) begin
        if (dsWrite) begin dsW = 1; dsA = dsAddr - 32; dsD = dsWData; end
        else eDsR = rdReg(dsAddr - 32);
      end
    end
    for (int a = 0; a < 3; a++) begin
      if (dsW && dsA == a) scr[a] = dsD;
      else if (ioW && ioA == a) scr[a] = ((scr[a] & ~ioM) | (ioD & ioM)) & 255;
    end
    if (dsW && dsA == 5) clr = dsD;
    else if (ioW && ioA == 5) clr = ioM & ioD;
    flg = ((flg & ~clr) | evtSet) & 15;
  endtask

  task automatic compareAll(string tag);
    cmp(tag, "ioRData", ioRData, eIoR);
    cmp(tag, "ioBitResult", ioBitResult, eBit);
    cmp(tag, "ioError", ioError, eIoE);
    cmp(tag, "dsRData", dsRData, eDsR);
    cmp(tag, "dsError", dsError, eDsE);
  endtask

  task automatic tick(string tag);
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compareAll(tag);
    ioValid = 1'b0; dsValid = 1'b0; evtSet = '0;
  endtask

  task automatic io(int op, int addr, int bsel, int data);
    ioValid = 1'b1; ioOp = 3'(op); ioAddr = 8'(addr);
    ioBitSel = 3'(bsel); ioWData = 8'(data);
  endtask

  task automatic ds(int wr, int addr, int data);
    dsValid = 1'b1; dsWrite = wr[0]; dsAddr = 8'(addr); dsWData = 8'(data);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) scr[i] = 0;
    // R1: outputs held at zero in reset, even with requests present
    io(0, 0, 0, 0); ds(0, 8'h25, 0);
    repeat (3) @(negedge clk);
    eIoR = 0; eBit = 0; eIoE = 0; eDsR = 0; eDsE = 0;
    compareAll("R1");
    ioValid = 1'b0; dsValid = 1'b0;
    rstN = 1'b1;
    tick("R1");
    io(0, 0, 0, 0); ds(0, 8'h25, 0); tick("R1");
    io(0, 2, 0, 0); ds(0, 8'h21, 0); tick("R1");
    // R2: byte write and one-cycle read
    io(1, 0, 0, 8'hA5); tick("R2");
    io(0, 0, 0, 0); tick("R2");
    tick("R2");
    // R3: data-space mapping
    ds(0, 8'h20, 0); tick("R3");
    ds(1, 8'h22, 8'h3C); tick("R3");
    io(0, 2, 0, 0); ds(0, 8'h22, 0); tick("R3");
    // R4: single-bit set/clear
    io(2, 1, 6, 0); tick("R4");
    io(3, 0, 0, 0); tick("R4");
    io(0, 1, 0, 0); ds(0, 8'h20, 0); tick("R4");
    // R5: bit test
    io(4, 0, 2, 0); tick("R5");
    io(4, 0, 0, 0); tick("R5");
    io(4, 1, 6, 0); tick("R5");
    // R6: bit ops above window, bad opcodes
    io(2, 8'h21, 0, 0); tick("R6");
    io(4, 8'h30, 1, 0); tick("R6");
    io(5, 0, 0, 8'hFF); tick("R6");
    io(7, 1, 0, 8'hFF); tick("R6");
    io(0, 0, 0, 0); ds(0, 8'h21, 0); tick("R6");
    // R7: short-address range and extended region
    io(1, 8'h40, 0, 8'hFF); tick("R7");
    io(1, 8'h41, 0, 8'hFF); tick("R7");
    io(0, 8'h42, 0, 0); tick("R7");
    ds(1, 8'h60, 8'hFF); tick("R7");
    ds(1, 8'h80, 8'hFF); tick("R7");
    ds(0, 8'h60, 0); tick("R7");
    ds(0, 8'hFF, 0); io(0, 0, 0, 0); tick("R7");
    io(0, 1, 0, 0); ds(0, 8'h22, 0); tick("R7");
    // R8: status flags
    evtSet = 4'b1011; tick("R8");
    io(0, 5, 0, 0); tick("R8");
    io(1, 5, 0, 8'h01); tick("R8");
    io(1, 5, 0, 8'h00); tick("R8");
    io(0, 5, 0, 0); tick("R8");
    io(1, 5, 0, 8'h02); evtSet = 4'b0010; tick("R8");
    ds(0, 8'h25, 0); tick("R8");
    // R9: bit ops on flags keep other pending flags
    io(2, 5, 3, 0); tick("R9");
    io(0, 5, 0, 0); tick("R9");
    io(3, 5, 1, 0); tick("R9");
    io(0, 5, 0, 0); tick("R9");
    evtSet = 4'b1111; tick("R9");
    io(2, 5, 0, 0); tick("R9");
    io(0, 5, 0, 0); tick("R9");
    io(4, 5, 0, 0); tick("R9");
    io(4, 5, 3, 0); tick("R9");
    // R10: reserved bits and addresses
    io(1, 3, 0, 8'hFF); tick("R10");
    io(0, 3, 0, 0); ds(0, 8'h23, 0); tick("R10");
    ds(1, 8'h5F, 8'hFF); tick("R10");
    io(0, 8'h3F, 0, 0); tick("R10");
    evtSet = 4'b1111; tick("R10");
    io(1, 5, 0, 8'hF0); tick("R10");
    io(0, 5, 0, 0); tick("R10");
    // R11: collisions between the ports
    io(1, 1, 0, 8'h11); ds(1, 8'h21, 8'h55); tick("R11");
    io(0, 1, 0, 0); tick("R11");
    io(1, 0, 0, 8'h66); ds(1, 8'h22, 8'h77); tick("R11");
    io(0, 0, 0, 0); ds(0, 8'h22, 0); tick("R11");
    io(2, 5, 1, 0); ds(1, 8'h25, 8'h04); tick("R11");
    io(0, 5, 0, 0); tick("R11");
    // R12: load/store below the window
    ds(1, 8'h10, 8'hFF); tick("R12");
    ds(0, 8'h1F, 0); tick("R12");
    ds(1, 8'h00, 8'hFF); tick("R12");
    io(0, 0, 0, 0); ds(0, 8'h21, 0); tick("R12");
    // mixed traffic, collisions with events (R2, R8, R9, R11)
    for (int n = 0; n < 600; n++) begin
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >>> 17); lfsr = lfsr ^ (lfsr << 5);
      if (lfsr[0]) io(lfsr[4:2] % 6, (lfsr[5] ? (lfsr[11:6] % 8) : (lfsr[11:6] + 8)),
                      lfsr[14:12], lfsr[22:15]);
      if (lfsr[1]) ds(lfsr[23], (lfsr[24] ? (8'h20 + (lfsr[27:25] % 8)) : lfsr[31:24]),
                      lfsr[30:23]);
      if (lfsr[29]) evtSet = lfsr[19:16];
      tick("R11");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule